// File: doc/BRIEF.md
# Paged MDIO Register Bridge

This block gives a simple host bus 32-bit register reads and writes on a device whose management port offers only 16-bit Clause 22 MDIO registers behind a page selector. The host presents one address, a direction flag and, for writes, a 32-bit word. The block splits the address into three fields: a page number, a small offset added to the device's data PHY address, and an even register index.

Each host access is carried out as a fixed series of steps. First a page-select frame is written. Then the block waits a programmable number of system clocks so that the new page can take effect. Finally it runs two 16-bit data frames, one for each half of the word, in a fixed order. MDC is divided down from the system clock. The MDIO line is driven through a separate output-enable, which is released during the turnaround and data field of read frames.

The block accepts one request at a time. It drops `req_ready` while an access is in progress and marks completion with a one-cycle `done`.

Top module: `mdio_page_bridge`

## Requirements
- R1: After reset, `req_ready` is 1 and `done`, `mdc` and `mdio_oe` are 0.
- R2: Every access starts with a write frame to PHY address 0x18, register 0. Its 16 data bits are the page, which is address bits [17:9] with zeros above.
- R3: Data frames use PHY address 0x10 OR address bits [8:6]. The even register index is {address bits [5:2], 0}. Address bits [1:0] have no effect.
- R4: A read fetches the low half from the even register first, then the high half from the next (odd) register, and returns `rdata` = {high, low}.
- R5: A write sends bits [31:16] to the odd register first, then bits [15:0] to the even register.
- R6: No data frame starts until at least SETTLE_CYCLES system clocks after the page frame ends.
- R7: Every frame is 64 MDC bits, sent MSB first. It consists of 32 preamble ones, start bits 01, an opcode (01 write, 10 read), a 5-bit PHY address, a 5-bit register address, a turnaround (10 on writes) and 16 data bits.
- R8: In a read frame, `mdio_oe` is 0 from the first turnaround bit through the last data bit, and read bits are taken at MDC rising edges. In all other bits `mdio_oe` is 1, and the line changes only at MDC falling edges.
- R9: MDC has a period of 2*MDC_HALF system clocks.
- R10: While an access is in progress, `req_ready` is 0 and any `req_valid` is ignored. `done` is high for exactly one cycle when the access ends.
- R11: While the block is idle, `mdio_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Paged register address |
| req_wdata | input | 32 | Write word |
| req_ready | output | 1 | Block idle, can accept a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read result, valid from done onwards |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO data out |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO data in |

## Verification
A request taken at a clock edge drops `req_ready` by the next negative clock edge, where the bench samples it. Frame content is not compared against a fixed cycle. The bench decodes each frame at MDC rising edges, as a device would, and places read data in the half period before the sampling rise. The read result and the full frame log are due at the `done` pulse. The bench waits for that pulse and checks everything there. The settle gap is measured in clock counts between the end of the page frame's last bit and the start of the next frame's first bit, and is checked only as a lower bound.

// File: rtl/mdio_page_pkg.sv
package mdio_page_pkg;
  localparam int ADDR_W     = 18;
  localparam int FRAME_BITS = 64;
  localparam int TA_BIT     = 46;
  localparam int DATA_BIT   = 48;
  localparam logic [4:0] PAGE_PHY      = 5'h18;
  localparam logic [4:0] DATA_PHY_BASE = 5'h10;
  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;

  typedef enum logic [2:0] {S_IDLE, S_PAGE, S_SETTLE, S_XFER1, S_XFER2} seq_t;

  function automatic logic [8:0] page_of(input logic [ADDR_W-1:0] a);
    return a[17:9];
  endfunction

  function automatic logic [4:0] even_index(input logic [ADDR_W-1:0] a);
    return {a[5:2], 1'b0};
  endfunction

  function automatic logic [4:0] data_phy(input logic [ADDR_W-1:0] a);
    return DATA_PHY_BASE | {2'b00, a[8:6]};
  endfunction

  function automatic logic [FRAME_BITS-1:0] build_frame(input logic [1:0] op,
      input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, op, phy, rg, 2'b10, d};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int MDC_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic mdc,
  output logic tick,
  output logic fall_evt,
  output logic rise_evt
);
  localparam int CW = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(MDC_HALF - 1);

  logic [CW-1:0] cnt;

  assign tick     = (cnt == LAST);
  assign fall_evt = tick & mdc;
  assign rise_evt = tick & ~mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_page_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fall_evt,
  input  logic                  rise_evt,
  input  logic                  start,
  input  logic                  is_read,
  input  logic [FRAME_BITS-1:0] frame,
  input  logic                  mdio_i,
  output logic                  busy,
  output logic                  done,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic [15:0]           rd_data
);
  localparam logic [6:0] END_IDX   = 7'(FRAME_BITS);
  localparam logic [6:0] TA_IDX    = 7'(TA_BIT);
  localparam logic [6:0] FIRST_RX  = 7'(DATA_BIT + 1);

  logic                  active;
  logic                  rd_mode;
  logic [6:0]            bit_idx;
  logic [FRAME_BITS-1:0] shreg;

  assign busy = active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      rd_mode <= 1'b0;
      bit_idx <= '0;
      shreg   <= '0;
      done    <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active  <= 1'b1;
          bit_idx <= '0;
          shreg   <= frame;
          rd_mode <= is_read;
        end
      end else if (fall_evt) begin
        if (bit_idx == END_IDX) begin
          active  <= 1'b0;
          mdio_oe <= 1'b0;
          mdio_o  <= 1'b1;
          done    <= 1'b1;
        end else begin
          mdio_o  <= shreg[FRAME_BITS-1];
          shreg   <= {shreg[FRAME_BITS-2:0], 1'b0};
          mdio_oe <= !(rd_mode && (bit_idx >= TA_IDX));
          bit_idx <= bit_idx + 7'd1;
        end
      end else if (rise_evt && rd_mode && (bit_idx >= FIRST_RX)) begin
        rd_data <= {rd_data[14:0], mdio_i};
      end
    end
  end
endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
  import mdio_page_pkg::*;
#(
  parameter int MDC_HALF      = 2,
  parameter int SETTLE_CYCLES = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              req_ready,
  output logic              done,
  output logic [31:0]       rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int SW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYCLES - 1);

  seq_t              state;
  logic              launched;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       wdata_q;
  logic [SW-1:0]     settle_cnt;

  // named internal events used by the checker
  logic              mdc_tick;
  logic              mdc_fall;
  logic              mdc_rise;
  logic              fr_start;
  logic              fr_done;
  logic              fr_busy;
  logic              fr_read;
  logic [FRAME_BITS-1:0] fr_bits;
  logic [15:0]       fr_rd;
  logic              frame_state;

  mdio_clkgen #(.MDC_HALF(MDC_HALF)) u_clk (
    .clk(clk), .rst_n(rst_n), .mdc(mdc),
    .tick(mdc_tick), .fall_evt(mdc_fall), .rise_evt(mdc_rise)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n), .fall_evt(mdc_fall), .rise_evt(mdc_rise),
    .start(fr_start), .is_read(fr_read), .frame(fr_bits), .mdio_i(mdio_i),
    .busy(fr_busy), .done(fr_done), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rd_data(fr_rd)
  );

  assign req_ready   = (state == S_IDLE);
  assign frame_state = (state == S_PAGE) || (state == S_XFER1) || (state == S_XFER2);
  assign fr_start    = frame_state && !launched && !fr_busy;

  always_comb begin
    fr_read = 1'b0;
    fr_bits = build_frame(OP_WR, PAGE_PHY, 5'd0, {7'd0, page_of(addr_q)});
    unique case (state)
      S_XFER1: begin
        if (wr_q) begin
          fr_bits = build_frame(OP_WR, data_phy(addr_q), even_index(addr_q) | 5'd1, wdata_q[31:16]);
        end else begin
          fr_read = 1'b1;
          fr_bits = build_frame(OP_RD, data_phy(addr_q), even_index(addr_q), 16'd0);
        end
      end
      S_XFER2: begin
        if (wr_q) begin
          fr_bits = build_frame(OP_WR, data_phy(addr_q), even_index(addr_q), wdata_q[15:0]);
        end else begin
          fr_read = 1'b1;
          fr_bits = build_frame(OP_RD, data_phy(addr_q), even_index(addr_q) | 5'd1, 16'd0);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      launched   <= 1'b0;
      wr_q       <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
      settle_cnt <= '0;
      done       <= 1'b0;
      rdata      <= '0;
    end else begin
      done <= 1'b0;
      if (fr_start) launched <= 1'b1;
      else if (fr_done) launched <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (req_valid) begin
            wr_q    <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            state   <= S_PAGE;
          end
        end
        S_PAGE: begin
          if (fr_done) begin
            settle_cnt <= '0;
            state      <= S_SETTLE;
          end
        end
        S_SETTLE: begin
          if (settle_cnt == SETTLE_LAST) state <= S_XFER1;
          else settle_cnt <= settle_cnt + 1'b1;
        end
        S_XFER1: begin
          if (fr_done) begin
            if (!wr_q) rdata[15:0] <= fr_rd;
            state <= S_XFER2;
          end
        end
        S_XFER2: begin
          if (fr_done) begin
            if (!wr_q) rdata[31:16] <= fr_rd;
            done  <= 1'b1;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_page_bridge_chk.sv
module mdio_page_bridge_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic ready,
  input logic done,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe,
  input logic mdc_tick,
  input logic mdc_fall
);
  a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_accept_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ready) |=> !ready);
  a_r10_done_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !$past(ready));
  a_r11_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !mdio_oe);
  a_r9_mdc_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !mdc_tick |=> $stable(mdc));
  a_r8_line_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !mdc_fall |=> ($stable(mdio_o) && $stable(mdio_oe)));
endmodule

bind mdio_page_bridge mdio_page_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ready(req_ready),
  .done(done), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .mdc_tick(mdc_tick), .mdc_fall(mdc_fall)
);

// File: tb/mdio_page_bridge_test.sv
module mdio_page_bridge_test;
  localparam int HALF   = 2;
  localparam int SETTLE = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, done, mdc, mdio_o, mdio_oe;
  logic [31:0] rdata;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;

  mdio_page_bridge #(.MDC_HALF(HALF), .SETTLE_CYCLES(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .done(done), .rdata(rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // device model: frame log decoded at MDC rising edges
  int          bcnt = 0;
  logic [63:0] sh = '0;
  bit          oe_bad = 0;
  logic [1:0]  cur_op = '0;
  logic [4:0]  cur_phy = '0;
  logic [4:0]  cur_reg = '0;
  logic [8:0]  dev_page = '0;
  logic [15:0] rdv = '0;
  int          nfr = 0;
  int          last_rise = 0;
  int          mdc_per = 0;
  logic [1:0]  f_op  [512];
  logic [4:0]  f_phy [512];
  logic [4:0]  f_reg [512];
  logic [15:0] f_dat [512];
  bit          f_bad [512];
  int          f_st  [512];
  int          f_end [512];

  function automatic logic [15:0] dev_val(input logic [8:0] pg, input logic [4:0] ph,
                                         input logic [4:0] rg);
    return {pg[6:0], ph[3:0], rg};
  endfunction

  always @(posedge mdc) begin
    logic b;
    bit exp_oe;
    mdc_per = cyc - last_rise;
    last_rise = cyc;
    if (bcnt != 0 || mdio_oe) begin
      exp_oe = !(cur_op == 2'b10 && bcnt >= 46);
      if (bcnt < 36) exp_oe = 1'b1;
      if (bcnt == 0) begin oe_bad = 0; f_st[nfr % 512] = cyc; end
      if (mdio_oe != exp_oe) oe_bad = 1;
      b = mdio_oe ? mdio_o : mdio_i;
      sh = {sh[62:0], b};
      bcnt++;
      if (bcnt == 36) cur_op = sh[1:0];
      if (bcnt == 41) cur_phy = sh[4:0];
      if (bcnt == 46) begin
        cur_reg = sh[4:0];
        rdv = dev_val(dev_page, cur_phy, cur_reg);
      end
      if (bcnt == 64) begin
        f_op [nfr % 512] = sh[29:28];
        f_phy[nfr % 512] = sh[27:23];
        f_reg[nfr % 512] = sh[22:18];
        f_dat[nfr % 512] = sh[15:0];
        f_end[nfr % 512] = cyc;
        f_bad[nfr % 512] = oe_bad || (sh[63:32] != 32'hFFFF_FFFF) || (sh[31:30] != 2'b01) ||
                           ((sh[29:28] == 2'b01) && (sh[17:16] != 2'b10)) ||
                           ((sh[29:28] != 2'b01) && (sh[29:28] != 2'b10));
        if (sh[29:28] == 2'b01 && sh[27:23] == 5'h18 && sh[22:18] == 5'd0)
          dev_page = sh[8:0];
        nfr++;
        bcnt = 0;
        cur_op = 2'b00;
      end
    end
  end

  always @(negedge mdc) begin
    if (bcnt >= 48 && cur_op == 2'b10) mdio_i = rdv[63 - bcnt];
    else mdio_i = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [17:0] a, input logic [31:0] wd,
                        input bit poke_busy);
    int guard;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10 busy after accept", req_ready, 0);
    if (poke_busy) begin
      repeat (100) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = ~a; req_wdata = ~wd;
      @(negedge clk);
      req_valid = 1'b0;
    end
    guard = 0;
    while (!done && guard < 5000) begin @(negedge clk); guard++; end
    chk(done == 1'b1, "R10 done arrives", done, 1);
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", done, 0);
  endtask

  task automatic check_frames(input int base, input bit wr, input logic [17:0] a,
                              input logic [31:0] wd);
    logic [4:0] phy;
    logic [4:0] ev;
    phy = 5'h10 | {2'b00, a[8:6]};
    ev  = {a[5:2], 1'b0};
    chk(nfr - base == 3, "R2 three frames", nfr - base, 3);
    chk(f_op[base % 512] == 2'b01 && f_phy[base % 512] == 5'h18 && f_reg[base % 512] == 0,
        "R2 page frame addr", {f_op[base % 512], f_phy[base % 512], f_reg[base % 512]}, {2'b01, 5'h18, 5'd0});
    chk(f_dat[base % 512] == {7'd0, a[17:9]}, "R2 page value", f_dat[base % 512], a[17:9]);
    for (int k = 0; k < 3; k++)
      chk(!f_bad[(base + k) % 512], "R7 R8 frame format", f_bad[(base + k) % 512], 0);
    chk(f_st[(base + 1) % 512] - f_end[base % 512] >= SETTLE, "R6 settle gap",
        f_st[(base + 1) % 512] - f_end[base % 512], SETTLE);
    if (wr) begin
      chk(f_op[(base+1)%512] == 2'b01 && f_phy[(base+1)%512] == phy && f_reg[(base+1)%512] == (ev | 5'd1)
          && f_dat[(base+1)%512] == wd[31:16], "R5 R3 high half first",
          {f_phy[(base+1)%512], f_reg[(base+1)%512], f_dat[(base+1)%512]}, {phy, ev | 5'd1, wd[31:16]});
      chk(f_op[(base+2)%512] == 2'b01 && f_phy[(base+2)%512] == phy && f_reg[(base+2)%512] == ev
          && f_dat[(base+2)%512] == wd[15:0], "R5 R3 low half second",
          {f_phy[(base+2)%512], f_reg[(base+2)%512], f_dat[(base+2)%512]}, {phy, ev, wd[15:0]});
    end else begin
      chk(f_op[(base+1)%512] == 2'b10 && f_phy[(base+1)%512] == phy && f_reg[(base+1)%512] == ev,
          "R4 R3 low read first", {f_phy[(base+1)%512], f_reg[(base+1)%512]}, {phy, ev});
      chk(f_op[(base+2)%512] == 2'b10 && f_phy[(base+2)%512] == phy && f_reg[(base+2)%512] == (ev | 5'd1),
          "R4 R3 high read second", {f_phy[(base+2)%512], f_reg[(base+2)%512]}, {phy, ev | 5'd1});
      chk(rdata == {dev_val(a[17:9], phy, ev | 5'd1), dev_val(a[17:9], phy, ev)}, "R4 rdata",
          rdata, {dev_val(a[17:9], phy, ev | 5'd1), dev_val(a[17:9], phy, ev)});
    end
  endtask

  always @(posedge clk) begin
    if (cyc == 150000 && !finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    chk(req_ready == 1 && done == 0 && mdc == 0 && mdio_oe == 0, "R1 reset state",
        {req_ready, done, mdc, mdio_oe}, 4'b1000);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(mdio_oe == 0, "R11 idle released", mdio_oe, 0);
    chk(mdc_per == 2 * HALF, "R9 mdc period", mdc_per, 2 * HALF);

    // sweep offsets, indices, pages and ignored low bits
    for (int i = 0; i < 16; i++) begin
      logic [8:0]  pg;
      logic [17:0] a;
      logic [31:0] wd;
      pg = (i == 0) ? 9'd0 : (i == 15) ? 9'h1FF : 9'((i * 37 + 5) % 512);
      a  = {pg, 3'(i % 8), 4'(i), 2'(i)};
      wd = 32'h1357_0000 ^ (i * 32'h0101_0F0F);
      base = nfr;
      access(1'b1, a, wd, 1'b0);
      check_frames(base, 1'b1, a, wd);
      base = nfr;
      access(1'b0, a, 32'd0, 1'b0);
      check_frames(base, 1'b0, a, 32'd0);
      chk(mdio_oe == 0, "R11 idle after access", mdio_oe, 0);
    end

    // R3: low address bits have no effect
    base = nfr;
    access(1'b0, {9'h0A5, 3'd6, 4'd9, 2'b11}, 32'd0, 1'b0);
    check_frames(base, 1'b0, {9'h0A5, 3'd6, 4'd9, 2'b00}, 32'd0);

    // R10: request while busy is ignored
    base = nfr;
    access(1'b1, {9'h033, 3'd2, 4'd7, 2'b00}, 32'hCAFE_F00D, 1'b1);
    check_frames(base, 1'b1, {9'h033, 3'd2, 4'd7, 2'b00}, 32'hCAFE_F00D);
    repeat (800) @(negedge clk);
    chk(nfr - base == 3, "R10 busy request ignored", nfr - base, 3);
    chk(req_ready == 1, "R10 idle again", req_ready, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule